// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the register file behind a processor core's system control coprocessor. The core reaches it through single-cycle transfer requests. Each request carries a direction bit (write into the block or read out of it), two opcode fields, a primary and a secondary register number, the index of the core register involved and a 32-bit data word. The block decodes the request in two levels. The first level uses the primary number. The second level uses the secondary number or the second opcode. One cycle later the block answers with read data, an undefined-access flag and a warning flag.

The block stores the control state that the memory system needs: the main and auxiliary control words, the translation table base, the domain access word, fault status and fault address, the process identifier and the coprocessor access word. It drives the enables for the memory management unit, the alignment check, both caches and the write buffer, the table base and the domain word directly to those units. It also exposes two read-only identification values that come from parameters. Some write addresses do not store anything. Instead they produce one-cycle commands to flush translation entries, either all of them or the entry for a single address.

Any access the block does not define is refused. A refused access raises the undefined flag for one cycle, returns zero data and leaves every register unchanged, so the core can take an undefined-instruction trap.

Top module: `sysctl_cp_regs`

## Requirements
- R1: For every request accepted with `req_valid`, `rsp_valid` is high exactly one cycle later. A legal read returns the register value on `rsp_rdata`. A write returns zero on `rsp_rdata`.
- R2: A request with `req_op1` non-zero, or with `req_rd` equal to 15, is undefined. An undefined request sets `rsp_undef`, returns zero data and changes no register.
- R3: Primary register 0 is read-only. With `req_op2` = 0 it returns the ID parameter, and with `req_op2` = 1 it returns the cache type parameter. A write to it, or any other `req_op2` value, is undefined.
- R4: Primary register 1 with `req_op2` = 0 is the 32-bit main control word, and with `req_op2` = 1 it is the 32-bit auxiliary control word. Any other `req_op2` value is undefined. In the main control word, bit 0 drives `mmu_en`, bit 1 drives `align_chk_en`, bit 2 drives `dcache_en`, bit 3 drives `wbuf_en`, bit 7 drives `big_endian` and bit 12 drives `icache_en`.
- R5: A write to the main control word whose bit 7 differs from the stored bit 7 is undefined, and the stored control word is left unchanged.
- R6: Primary register 2 is the table base. A write stores the data with bits 13:0 cleared and drives the result on `tbl_base`. A read returns the stored value. `rsp_warn` is high for a legal write whose bits 13:0 are non-zero, and low otherwise.
- R7: Primary register 3 is a 32-bit domain word with no masking. It is read/write and drives `domain_ctl`.
- R8: Primary register 5 keeps only bits 7:0 of a write and reads back with bits 31:8 as zero. Primary register 6 is a full 32-bit read/write register.
- R9: A write to primary register 7 is accepted with no effect on any register or output. A read of primary register 7 or 8 is undefined.
- R10: A write to primary register 8 with `req_op2` = 0 gives a one-cycle `tlb_inv_all` together with the response. Any other `req_op2` value gives a one-cycle `tlb_inv_one`, with the written word on `tlb_inv_addr`. No other request raises either pulse.
- R11: Primary register 13 is the process identifier. It needs `req_op2` = 0 and `req_crm` = 0, and is undefined otherwise. Writing a non-zero value is undefined, and the identifier stays zero.
- R12: Primary register 15 with `req_crm` = 1 is a 32-bit read/write access word. Any other `req_crm` value is undefined. Primary numbers 4, 9, 10, 11, 12 and 14 are undefined.
- R13: Synchronous reset clears all stored words and all outputs to zero. This disables the memory management unit, the caches and the alignment check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present this cycle |
| req_write | input | 1 | 1 = core writes into block, 0 = core reads |
| req_op1 | input | 3 | First opcode field, must be zero |
| req_op2 | input | 3 | Second opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_rd | input | 4 | Core register index (15 is illegal) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero on writes and refusals |
| rsp_undef | output | 1 | Request was undefined |
| rsp_warn | output | 1 | Table base write carried non-zero low bits |
| mmu_en | output | 1 | Memory management unit enable |
| align_chk_en | output | 1 | Alignment check enable |
| dcache_en | output | 1 | Data cache enable |
| wbuf_en | output | 1 | Write buffer enable |
| icache_en | output | 1 | Instruction cache enable |
| big_endian | output | 1 | Endianness selection |
| tbl_base | output | 32 | Aligned translation table base |
| domain_ctl | output | 32 | Domain access word |
| tlb_inv_all | output | 1 | One-cycle flush-all command |
| tlb_inv_one | output | 1 | One-cycle flush-by-address command |
| tlb_inv_addr | output | 32 | Address for the flush-by-address command |

## Verification
The bench builds the block with two distinctive non-zero identification values, 32'h4115A0C3 and 32'h0B1AA1AA. These make the register 0 read paths and the zero-on-refusal behaviour visible on the data bus. The alignment width is left at 14 and the fault status width at 8, so the masking boundaries sit exactly on the edges named in the requirements. With these values, one sequence reaches every primary register, every refusal reason and both flush commands, followed by a second reset with state already loaded.

// File: rtl/cp_pkg.sv
package cp_pkg;

    localparam int XLEN   = 32;
    localparam int OP_W   = 3;
    localparam int REG_W  = 4;

    // Bit positions inside the main control word
    localparam int CTL_MMU    = 0;
    localparam int CTL_ALIGN  = 1;
    localparam int CTL_DCACHE = 2;
    localparam int CTL_WBUF   = 3;
    localparam int CTL_BIG    = 7;
    localparam int CTL_ICACHE = 12;

    typedef struct packed {
        logic             write;
        logic [OP_W-1:0]  op1;
        logic [OP_W-1:0]  op2;
        logic [REG_W-1:0] crn;
        logic [REG_W-1:0] crm;
        logic [REG_W-1:0] rd;
        logic [XLEN-1:0]  wdata;
    } cp_req_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_CTYPE,
        SEL_CTRL,
        SEL_AUX,
        SEL_TBASE,
        SEL_DOMAIN,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_CACHEOP,
        SEL_TLB,
        SEL_PROCID,
        SEL_ACCESS
    } cp_sel_e;

    typedef struct packed {
        cp_sel_e sel;
        logic    illegal;
        logic    warn;
    } cp_dec_t;

    // Mask that clears the low n bits of a word
    function automatic logic [XLEN-1:0] high_mask(input int n);
        logic [XLEN-1:0] m;
        m = '1;
        for (int i = 0; i < XLEN; i++) begin
            if (i < n) m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/cp_decode.sv
module cp_decode
    import cp_pkg::*;
#(
    parameter int ALIGN_BITS = 14,
    parameter int PC_INDEX   = 15
) (
    input  cp_req_t req,
    input  logic    cur_big,
    output cp_dec_t dec
);

    localparam logic [XLEN-1:0] LOW_MASK = ~high_mask(ALIGN_BITS);

    logic bad;
    logic wrn;
    cp_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        bad = 1'b0;
        wrn = 1'b0;
        case (req.crn)
            4'd0: begin
                if (req.write || req.op2 > 3'd1) bad = 1'b1;
                else sel = (req.op2 == 3'd0) ? SEL_ID : SEL_CTYPE;
            end
            4'd1: begin
                if (req.op2 == 3'd0) begin
                    sel = SEL_CTRL;
                    if (req.write && (req.wdata[CTL_BIG] != cur_big)) bad = 1'b1;
                end else if (req.op2 == 3'd1) begin
                    sel = SEL_AUX;
                end else begin
                    bad = 1'b1;
                end
            end
            4'd2: begin
                sel = SEL_TBASE;
                wrn = req.write && ((req.wdata & LOW_MASK) != '0);
            end
            4'd3: sel = SEL_DOMAIN;
            4'd5: sel = SEL_FSTAT;
            4'd6: sel = SEL_FADDR;
            4'd7: begin
                sel = SEL_CACHEOP;
                if (!req.write) bad = 1'b1;
            end
            4'd8: begin
                sel = SEL_TLB;
                if (!req.write) bad = 1'b1;
            end
            4'd13: begin
                sel = SEL_PROCID;
                if (req.op2 != '0 || req.crm != '0) bad = 1'b1;
                if (req.write && req.wdata != '0) bad = 1'b1;
            end
            4'd15: begin
                if (req.crm == 4'd1) sel = SEL_ACCESS;
                else bad = 1'b1;
            end
            default: bad = 1'b1;
        endcase
        if (req.op1 != '0 || req.rd == REG_W'(PC_INDEX)) bad = 1'b1;
        dec.sel     = sel;
        dec.illegal = bad;
        dec.warn    = wrn && !bad;
    end

endmodule

// File: rtl/cp_regbank.sv
module cp_regbank
    import cp_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h0,
    parameter logic [31:0] CTYPE_VALUE = 32'h0,
    parameter int          ALIGN_BITS  = 14,
    parameter int          FSR_BITS    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  cp_sel_e         sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] ctrl_q,
    output logic [XLEN-1:0] tbase_q,
    output logic [XLEN-1:0] domain_q
);

    localparam logic [XLEN-1:0] TB_MASK = high_mask(ALIGN_BITS);

    logic [XLEN-1:0]     aux_q;
    logic [FSR_BITS-1:0] fstat_q;
    logic [XLEN-1:0]     faddr_q;
    logic [XLEN-1:0]     procid_q;
    logic [XLEN-1:0]     access_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            aux_q    <= '0;
            tbase_q  <= '0;
            domain_q <= '0;
            fstat_q  <= '0;
            faddr_q  <= '0;
            procid_q <= '0;
            access_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL:   ctrl_q   <= wdata;
                SEL_AUX:    aux_q    <= wdata;
                SEL_TBASE:  tbase_q  <= wdata & TB_MASK;
                SEL_DOMAIN: domain_q <= wdata;
                SEL_FSTAT:  fstat_q  <= wdata[FSR_BITS-1:0];
                SEL_FADDR:  faddr_q  <= wdata;
                SEL_PROCID: procid_q <= wdata;
                SEL_ACCESS: access_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_ID:     rd_data = ID_VALUE;
            SEL_CTYPE:  rd_data = CTYPE_VALUE;
            SEL_CTRL:   rd_data = ctrl_q;
            SEL_AUX:    rd_data = aux_q;
            SEL_TBASE:  rd_data = tbase_q & TB_MASK;
            SEL_DOMAIN: rd_data = domain_q;
            SEL_FSTAT:  rd_data = XLEN'(fstat_q);
            SEL_FADDR:  rd_data = faddr_q;
            SEL_PROCID: rd_data = procid_q;
            SEL_ACCESS: rd_data = access_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cp_tlb_cmd.sv
module cp_tlb_cmd
    import cp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic [OP_W-1:0] op2,
    input  logic [XLEN-1:0] wdata,
    output logic            inv_all,
    output logic            inv_one,
    output logic [XLEN-1:0] inv_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_all  <= 1'b0;
            inv_one  <= 1'b0;
            inv_addr <= '0;
        end else begin
            inv_all  <= fire && (op2 == '0);
            inv_one  <= fire && (op2 != '0);
            inv_addr <= (fire && op2 != '0) ? wdata : '0;
        end
    end

endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
    import cp_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h0000_0001,
    parameter logic [31:0] CTYPE_VALUE = 32'h0000_0002,
    parameter int          ALIGN_BITS  = 14,
    parameter int          FSR_BITS    = 8,
    parameter int          PC_INDEX    = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_op1,
    input  logic [2:0]  req_op2,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [3:0]  req_rd,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_undef,
    output logic        rsp_warn,
    output logic        mmu_en,
    output logic        align_chk_en,
    output logic        dcache_en,
    output logic        wbuf_en,
    output logic        icache_en,
    output logic        big_endian,
    output logic [31:0] tbl_base,
    output logic [31:0] domain_ctl,
    output logic        tlb_inv_all,
    output logic        tlb_inv_one,
    output logic [31:0] tlb_inv_addr
);

    cp_req_t         req;
    cp_dec_t         dec;
    logic [XLEN-1:0] rd_data;
    logic [XLEN-1:0] ctrl_q;
    logic            accept;

    assign req = '{write: req_write, op1: req_op1, op2: req_op2, crn: req_crn,
                   crm: req_crm, rd: req_rd, wdata: req_wdata};

    assign accept = req_valid && !dec.illegal;

    cp_decode #(.ALIGN_BITS(ALIGN_BITS), .PC_INDEX(PC_INDEX)) u_dec (
        .req     (req),
        .cur_big (ctrl_q[CTL_BIG]),
        .dec     (dec)
    );

    cp_regbank #(
        .ID_VALUE    (ID_VALUE),
        .CTYPE_VALUE (CTYPE_VALUE),
        .ALIGN_BITS  (ALIGN_BITS),
        .FSR_BITS    (FSR_BITS)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept && req_write),
        .sel      (dec.sel),
        .wdata    (req_wdata),
        .rd_data  (rd_data),
        .ctrl_q   (ctrl_q),
        .tbase_q  (tbl_base),
        .domain_q (domain_ctl)
    );

    cp_tlb_cmd u_tlb (
        .clk      (clk),
        .rst      (rst),
        .fire     (accept && req_write && dec.sel == SEL_TLB),
        .op2      (req_op2),
        .wdata    (req_wdata),
        .inv_all  (tlb_inv_all),
        .inv_one  (tlb_inv_one),
        .inv_addr (tlb_inv_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_undef <= 1'b0;
            rsp_warn  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (accept && !req_write) ? rd_data : '0;
            rsp_undef <= req_valid && dec.illegal;
            rsp_warn  <= req_valid && dec.warn;
        end
    end

    assign mmu_en       = ctrl_q[CTL_MMU];
    assign align_chk_en = ctrl_q[CTL_ALIGN];
    assign dcache_en    = ctrl_q[CTL_DCACHE];
    assign wbuf_en      = ctrl_q[CTL_WBUF];
    assign icache_en    = ctrl_q[CTL_ICACHE];
    assign big_endian   = ctrl_q[CTL_BIG];

endmodule

// File: rtl/cp_regs_checker.sv
module cp_regs_checker #(
    parameter int ALIGN_BITS = 14
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_undef,
    input logic        rsp_warn,
    input logic [31:0] rsp_rdata,
    input logic        tlb_inv_all,
    input logic        tlb_inv_one,
    input logic [31:0] tbl_base,
    input logic        big_endian
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1

    AST_UNDEF_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_undef |-> (rsp_rdata == '0 && rsp_valid)); // R2

    AST_ENDIAN_HELD: assert property (@(posedge clk) disable iff (rst)
        $stable(big_endian)); // R5

    AST_TBASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        tbl_base[ALIGN_BITS-1:0] == '0); // R6

    AST_WARN_NOT_UNDEF: assert property (@(posedge clk) disable iff (rst)
        rsp_warn |-> (rsp_valid && !rsp_undef)); // R6

    AST_TLB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tlb_inv_all, tlb_inv_one})); // R10

    AST_TLB_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        (tlb_inv_all || tlb_inv_one) |-> (rsp_valid && !rsp_undef)); // R10

endmodule

bind sysctl_cp_regs cp_regs_checker #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_undef   (rsp_undef),
    .rsp_warn    (rsp_warn),
    .rsp_rdata   (rsp_rdata),
    .tlb_inv_all (tlb_inv_all),
    .tlb_inv_one (tlb_inv_one),
    .tbl_base    (tbl_base),
    .big_endian  (big_endian)
);

// File: tb/tb_sysctl_cp_regs.sv
module tb_sysctl_cp_regs;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] ID_V       = 32'h4115_A0C3;
    localparam logic [31:0] CT_V       = 32'h0B1A_A1AA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_op1 = '0;
    logic [2:0]  req_op2 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [3:0]  req_rd  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_undef, rsp_warn;
    logic [31:0] rsp_rdata;
    logic        mmu_en, align_chk_en, dcache_en, wbuf_en, icache_en, big_endian;
    logic [31:0] tbl_base, domain_ctl, tlb_inv_addr;
    logic        tlb_inv_all, tlb_inv_one;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        undef;
        logic        warn;
        logic        inv_all;
        logic        inv_one;
        logic [31:0] addr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cp_regs #(.ID_VALUE(ID_V), .CTYPE_VALUE(CT_V)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_op1(req_op1), .req_op2(req_op2), .req_crn(req_crn), .req_crm(req_crm),
        .req_rd(req_rd), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_warn(rsp_warn),
        .mmu_en(mmu_en), .align_chk_en(align_chk_en), .dcache_en(dcache_en),
        .wbuf_en(wbuf_en), .icache_en(icache_en), .big_endian(big_endian),
        .tbl_base(tbl_base), .domain_ctl(domain_ctl), .tlb_inv_all(tlb_inv_all),
        .tlb_inv_one(tlb_inv_one), .tlb_inv_addr(tlb_inv_addr)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, expected response pushed to the scoreboard
    task automatic acc(input logic w, input logic [2:0] o1, input logic [2:0] o2,
                       input logic [3:0] n, input logic [3:0] m, input logic [3:0] r,
                       input logic [31:0] wd, input logic [31:0] er, input logic eu,
                       input logic ew, input logic eia, input logic eio, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_op1 = o1; req_op2 = o2;
        req_crn = n; req_crm = m; req_rd = r; req_wdata = wd;
        e.rdata = er; e.undef = eu; e.warn = ew; e.inv_all = eia; e.inv_one = eio;
        e.addr = eio ? wd : 32'h0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic rd(input logic [3:0] n, input logic [2:0] o2, input logic [3:0] m,
                      input logic [31:0] er, input logic eu, input string tag);
        acc(1'b0, 3'd0, o2, n, m, 4'd2, 32'h0, eu ? 32'h0 : er, eu, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [3:0] n, input logic [2:0] o2, input logic [3:0] m,
                      input logic [31:0] wd, input logic eu, input logic ew, input string tag);
        acc(1'b1, 3'd0, o2, n, m, 4'd3, wd, 32'h0, eu, ew, 1'b0, 1'b0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R1 unexpected response actual=1 expected=0");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rsp_rdata !== e.rdata || rsp_undef !== e.undef || rsp_warn !== e.warn ||
                    tlb_inv_all !== e.inv_all || tlb_inv_one !== e.inv_one ||
                    (e.inv_one && tlb_inv_addr !== e.addr)) begin
                    fails++;
                    $display("FAIL %s actual=%h/u%b/w%b/a%b/o%b/%h expected=%h/u%b/w%b/a%b/o%b/%h",
                             t, rsp_rdata, rsp_undef, rsp_warn, tlb_inv_all, tlb_inv_one,
                             tlb_inv_addr, e.rdata, e.undef, e.warn, e.inv_all, e.inv_one, e.addr);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R13 reset state
        chk({31'h0, rsp_valid}, 32'h0, "R13 rsp_valid in reset");
        chk({26'h0, mmu_en, align_chk_en, dcache_en, wbuf_en, icache_en, big_endian}, 32'h0,
            "R13 control outputs in reset");
        chk(tbl_base, 32'h0, "R13 table base in reset");
        rst = 1'b0;

        // R3 identification registers
        rd(4'd0, 3'd0, 4'd0, ID_V, 1'b0, "R3 read main id");
        rd(4'd0, 3'd1, 4'd0, CT_V, 1'b0, "R3 read cache type");
        rd(4'd0, 3'd2, 4'd0, 32'h0, 1'b1, "R3 op2=2 undefined");
        wr(4'd0, 3'd0, 4'd0, 32'h1234, 1'b1, 1'b0, "R3 write id undefined");
        // R2 illegal fields
        acc(1'b0, 3'd0, 3'd0, 4'd0, 4'd0, 4'd15, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0,
            "R2 rd=15 undefined");
        acc(1'b0, 3'd1, 3'd0, 4'd0, 4'd0, 4'd1, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0,
            "R2 op1=1 undefined");
        idle();

        // R4 control words
        wr(4'd1, 3'd0, 4'd0, 32'h0000_1005, 1'b0, 1'b0, "R4 write main control");
        rd(4'd1, 3'd0, 4'd0, 32'h0000_1005, 1'b0, "R1 R4 read main control");
        wr(4'd1, 3'd1, 4'd0, 32'h0000_00A5, 1'b0, 1'b0, "R4 write aux control");
        rd(4'd1, 3'd1, 4'd0, 32'h0000_00A5, 1'b0, "R4 read aux control");
        rd(4'd1, 3'd3, 4'd0, 32'h0, 1'b1, "R4 op2=3 undefined");
        idle();
        chk({26'h0, mmu_en, align_chk_en, dcache_en, wbuf_en, icache_en, big_endian},
            32'b101010, "R4 enables after 0x1005");

        // R5 endianness change refused
        wr(4'd1, 3'd0, 4'd0, 32'h0000_1085, 1'b1, 1'b0, "R5 endian flip undefined");
        rd(4'd1, 3'd0, 4'd0, 32'h0000_1005, 1'b0, "R5 control unchanged");
        wr(4'd1, 3'd0, 4'd0, 32'h0000_000A, 1'b0, 1'b0, "R4 write control 0xA");
        idle();
        chk({26'h0, mmu_en, align_chk_en, dcache_en, wbuf_en, icache_en, big_endian},
            32'b010100, "R4 enables after 0xA");

        // R6 table base
        wr(4'd2, 3'd0, 4'd0, 32'h1234_5678, 1'b0, 1'b1, "R6 unaligned base warns");
        rd(4'd2, 3'd0, 4'd0, 32'h1234_4000, 1'b0, "R6 base masked");
        idle();
        chk(tbl_base, 32'h1234_4000, "R6 tbl_base output");
        wr(4'd2, 3'd0, 4'd0, 32'h0004_C000, 1'b0, 1'b0, "R6 aligned base no warn");
        rd(4'd2, 3'd0, 4'd0, 32'h0004_C000, 1'b0, "R6 aligned base read");

        // R7 domain
        wr(4'd3, 3'd0, 4'd0, 32'hFFFF_0001, 1'b0, 1'b0, "R7 write domain");
        rd(4'd3, 3'd0, 4'd0, 32'hFFFF_0001, 1'b0, "R7 read domain");
        acc(1'b1, 3'd2, 3'd0, 4'd3, 4'd0, 4'd1, 32'h5555_5555, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0,
            "R2 op1 write refused");
        rd(4'd3, 3'd0, 4'd0, 32'hFFFF_0001, 1'b0, "R2 domain unchanged");
        idle();
        chk(domain_ctl, 32'hFFFF_0001, "R7 domain output");

        // R8 fault status and address
        wr(4'd5, 3'd0, 4'd0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R8 write fault status");
        rd(4'd5, 3'd0, 4'd0, 32'h0000_00EF, 1'b0, "R8 fault status 8 bits");
        wr(4'd6, 3'd0, 4'd0, 32'hCAFE_F00D, 1'b0, 1'b0, "R8 write fault address");
        rd(4'd6, 3'd0, 4'd0, 32'hCAFE_F00D, 1'b0, "R8 read fault address");

        // R9 cache operations
        wr(4'd7, 3'd5, 4'd0, 32'hCAFE_0000, 1'b0, 1'b0, "R9 cache op accepted");
        rd(4'd6, 3'd0, 4'd0, 32'hCAFE_F00D, 1'b0, "R9 cache op no effect");
        rd(4'd7, 3'd0, 4'd0, 32'h0, 1'b1, "R9 read reg7 undefined");
        rd(4'd8, 3'd0, 4'd0, 32'h0, 1'b1, "R9 read reg8 undefined");

        // R10 TLB commands
        acc(1'b1, 3'd0, 3'd0, 4'd8, 4'd7, 4'd1, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0,
            "R10 flush all");
        acc(1'b1, 3'd0, 3'd1, 4'd8, 4'd7, 4'd1, 32'h8000_1000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1,
            "R10 flush one");
        rd(4'd3, 3'd0, 4'd0, 32'hFFFF_0001, 1'b0, "R10 no pulse on other access");

        // R11 process id
        wr(4'd13, 3'd0, 4'd0, 32'h0, 1'b0, 1'b0, "R11 write zero pid");
        wr(4'd13, 3'd0, 4'd0, 32'h5, 1'b1, 1'b0, "R11 nonzero pid undefined");
        rd(4'd13, 3'd0, 4'd0, 32'h0, 1'b0, "R11 pid stays zero");
        rd(4'd13, 3'd1, 4'd0, 32'h0, 1'b1, "R11 op2 nonzero undefined");
        rd(4'd13, 3'd0, 4'd2, 32'h0, 1'b1, "R11 crm nonzero undefined");

        // R12 access word and unknown primaries
        wr(4'd15, 3'd0, 4'd1, 32'h0000_3FFF, 1'b0, 1'b0, "R12 write access word");
        rd(4'd15, 3'd0, 4'd1, 32'h0000_3FFF, 1'b0, "R12 read access word");
        rd(4'd15, 3'd0, 4'd0, 32'h0, 1'b1, "R12 crm=0 undefined");
        rd(4'd4, 3'd0, 4'd0, 32'h0, 1'b1, "R12 reg4 undefined");
        wr(4'd9, 3'd0, 4'd0, 32'h1, 1'b1, 1'b0, "R12 reg9 undefined");
        rd(4'd14, 3'd0, 4'd0, 32'h0, 1'b1, "R12 reg14 undefined");
        idle();

        // R13 second reset with state loaded
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk({26'h0, mmu_en, align_chk_en, dcache_en, wbuf_en, icache_en, big_endian}, 32'h0,
            "R13 enables cleared");
        chk(domain_ctl, 32'h0, "R13 domain cleared");
        rd(4'd2, 3'd0, 4'd0, 32'h0, 1'b0, "R13 base reads zero");
        rd(4'd15, 3'd0, 4'd1, 32'h0, 1'b0, "R13 access word zero");
        idle();
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R1 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule